// File: doc/BRIEF.md
# Parallel flash identification prober

This block is a bus master that asks a byte-wide parallel flash for its manufacturer and device codes. When it sees a start pulse, it places the flash in identification mode with a three-write unlock-and-enter sequence. It waits a long settling time, then reads the manufacturer byte at offset 0 and the device byte at offset 1. A byte equal to the continuation code 0x7F causes a second read, and that second byte is appended below the first to form a 16-bit code. The block then sends the three-write exit sequence and waits for it to take effect. Last, it reports whether both codes match the expected values that arrive on input ports.

Every bus access is a strobe held with stable address and data until the target acknowledges it, so any number of wait states is accepted. All settling delays are parameters counted in clock cycles. The defaults assume a 100 MHz clock: 10 us between unlock writes, 10 ms after the entry command and 40 us after the exit command.

Top module: `flash_id_probe`

## Requirements
- R1: After start, the first three bus accesses are writes of 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0x90 to 0x5555.
- R2: Each unlock write is followed by more than GAP_CYC idle clock cycles before the next access begins. The entry write (0x90) is followed by more than ENTRY_CYC idle cycles before the first read begins.
- R3: The manufacturer byte is read at offset 0x000, and the device byte is read next at offset 0x001. A byte that is not 0x7F is reported zero-extended (upper byte 0x00).
- R4: A manufacturer byte of 0x7F causes a read of offset 0x100, giving mfr_id = {0x7F, that byte}. A device byte of 0x7F causes a read of offset 0x101, giving dev_id = {0x7F, that byte}. The read order is 0x000, 0x001, then 0x100 if needed, then 0x101 if needed. No other read is made.
- R5: After the reads, the block writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xF0 to 0x5555. The first two of these writes are each followed by more than GAP_CYC idle cycles. done rises more than EXIT_CYC cycles after the 0xF0 write is acknowledged.
- R6: parity_err is 1 when the last manufacturer byte read has an even number of ones, and 0 when the count is odd. The match result is produced either way.
- R7: match is 1 only when mfr_id equals exp_mfr and dev_id equals exp_dev, comparing all 16 bits of each.
- R8: A strobe (bus_wr or bus_rd) stays high, with stable address and write data, until a cycle in which bus_ack is high. bus_wr and bus_rd are never high together. Read data is taken in the acknowledge cycle.
- R9: done is a one-cycle pulse. A start while a probe is running is ignored. match, parity_err, mfr_id and dev_id hold their values until the next probe completes, even if the expected-ID inputs change.
- R10: While rst_n is low, and after reset until a start, bus_wr, bus_rd, busy, done, match and parity_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a probe when idle |
| exp_mfr | input | 16 | Expected extended manufacturer code |
| exp_dev | input | 16 | Expected extended device code |
| bus_addr | output | ADDR_W | Flash byte address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack on a read |
| bus_wr | output | 1 | Write strobe, held until acknowledged |
| bus_rd | output | 1 | Read strobe, held until acknowledged |
| bus_ack | input | 1 | Access acknowledge from the target |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| match | output | 1 | Both codes equal the expected values |
| parity_err | output | 1 | Last manufacturer byte had even parity |
| mfr_id | output | 16 | Extended manufacturer code read |
| dev_id | output | 16 | Extended device code read |

## Verification
The bench builds the block with ADDR_W = 16, GAP_CYC = 3, ENTRY_CYC = 20 and EXIT_CYC = 8. With these values every settling window lasts a few dozen cycles, so the idle time around each window can be measured and compared against its bound within a short run. The memory model answers each access after 0 to 3 wait states. The stimulus covers no continuation, continuation on one field only and on both fields, together with parity that is odd and parity that is even. It also includes an expected code that matches only the low byte of an extended code.

// File: rtl/flash_probe_pkg.sv
// Package: shared constants and the sequencer step type for the flash
// identification prober. Assumes a byte-wide flash with 16-bit command
// addresses.
package flash_probe_pkg;

    localparam int BYTE_W = 8;
    localparam int ID_W   = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] CONT_CODE  = 8'h7F;
    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [BYTE_W-1:0] CMD_ENTER  = 8'h90;
    localparam logic [BYTE_W-1:0] CMD_LEAVE  = 8'hF0;

    localparam logic [15:0] ADR_KEY_FIRST  = 16'h5555;
    localparam logic [15:0] ADR_KEY_SECOND = 16'h2AAA;
    localparam logic [15:0] ADR_MAKER      = 16'h0000;
    localparam logic [15:0] ADR_PART       = 16'h0001;
    localparam logic [15:0] ADR_MAKER_EXT  = 16'h0100;
    localparam logic [15:0] ADR_PART_EXT   = 16'h0101;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_EN_A, ST_EN_A_GAP,
        ST_EN_B, ST_EN_B_GAP,
        ST_EN_C, ST_SETTLE,
        ST_RD_MFR, ST_RD_DEV, ST_RD_MFR_X, ST_RD_DEV_X,
        ST_EX_A, ST_EX_A_GAP,
        ST_EX_B, ST_EX_B_GAP,
        ST_EX_C, ST_EX_WAIT,
        ST_FINISH
    } probe_step_t;

endpackage

// File: rtl/probe_bus_port.sv
// Module: probe_bus_port
// Runs one byte-bus access at a time. A request is taken only while no strobe
// is up. The strobe, address and data are held until bus_ack is high. A
// one-cycle fin pulse then returns the byte read.
// Assumes the requester waits for fin before it requests again.
module probe_bus_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic              fin,
    output logic [DATA_W-1:0] fin_data
);

    logic active;
    assign active = bus_wr || bus_rd;

    // Launch a request, hold it until acknowledged, then report completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
            fin       <= 1'b0;
            fin_data  <= '0;
        end else begin
            fin <= 1'b0;
            if (active && bus_ack) begin
                bus_wr   <= 1'b0;
                bus_rd   <= 1'b0;
                fin      <= 1'b1;
                fin_data <= bus_rdata;
            end else if (req && !active) begin
                bus_addr  <= req_addr;
                bus_wdata <= req_wdata;
                bus_wr    <= req_wr;
                bus_rd    <= !req_wr;
            end
        end
    end

    // R8: the two strobes never overlap
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R8: an unacknowledged access holds its strobe, address and data
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bus_ack) |=> (active && $stable(bus_addr)
                                  && $stable(bus_wdata) && $stable(bus_wr)));

    // R8: completion is reported only for an access that was acknowledged
    a_r8_fin_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !active);

endmodule

// File: rtl/probe_delay_timer.sv
// Module: probe_delay_timer
// Down-counter for the settling windows. A load sets the count, which then
// falls by one each cycle and stops at zero. idle is high at zero.
// Assumes the count is loaded only when the sequencer enters a wait step.
module probe_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             idle
);

    logic [CNT_W-1:0] count;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign idle = (count == '0);

    // R2: without a load the count never grows
    a_r2_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> count <= $past(count));

endmodule

// File: rtl/probe_id_eval.sv
// Module: probe_id_eval
// Combinational judge of the codes read. It checks the last manufacturer byte
// for odd parity, and compares each extended field with its expected value.
// Assumes its inputs are stable when the sequencer finishes.
module probe_id_eval
    import flash_probe_pkg::*;
(
    input  logic [ID_W-1:0]   mfr_id,
    input  logic [ID_W-1:0]   dev_id,
    input  logic [BYTE_W-1:0] last_mfr,
    input  logic [ID_W-1:0]   exp_mfr,
    input  logic [ID_W-1:0]   exp_dev,
    output logic              odd_ok,
    output logic              equal
);

    logic [1:0] field_eq;
    logic [ID_W-1:0] got  [2];
    logic [ID_W-1:0] want [2];

    assign got[0]  = mfr_id;
    assign got[1]  = dev_id;
    assign want[0] = exp_mfr;
    assign want[1] = exp_dev;

    // One full-width comparator per code field.
    for (genvar f = 0; f < 2; f++) begin : g_field
        assign field_eq[f] = (got[f] == want[f]);
    end

    assign equal  = &field_eq;
    assign odd_ok = ^last_mfr;

endmodule

// File: rtl/probe_seq.sv
// Module: probe_seq
// Step sequencer for one probe. It walks the entry writes, the settling waits,
// the reads (with continuation extension) and the exit writes. Each access is
// sent to the bus port, and the sequencer waits for its fin pulse.
// Assumes the delay parameters fit in CNT_W bits.
module probe_seq
    import flash_probe_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 8,
    parameter int GAP_CYC   = 3,
    parameter int ENTRY_CYC = 20,
    parameter int EXIT_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fin,
    input  logic [BYTE_W-1:0] fin_data,
    input  logic              tmr_idle,
    output logic              req,
    output logic              req_wr,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BYTE_W-1:0] req_wdata,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              busy,
    output logic              finish,
    output logic [ID_W-1:0]   mfr_id,
    output logic [ID_W-1:0]   dev_id,
    output logic [BYTE_W-1:0] last_mfr
);

    probe_step_t step, nxt;
    logic        issued;
    logic        is_acc;
    logic        is_wait;

    // Decode the current step into an access or a wait, and pick its successor.
    always_comb begin
        is_acc    = 1'b0;
        is_wait   = 1'b0;
        req_wr    = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        tmr_val   = '0;
        nxt       = step;
        case (step)
            ST_EN_A: begin
                is_acc = 1'b1; req_wr = 1'b1; req_addr = ADDR_W'(ADR_KEY_FIRST);
                req_wdata = KEY_FIRST; tmr_val = CNT_W'(GAP_CYC); nxt = ST_EN_A_GAP;
            end
            ST_EN_B: begin
                is_acc = 1'b1; req_wr = 1'b1; req_addr = ADDR_W'(ADR_KEY_SECOND);
                req_wdata = KEY_SECOND; tmr_val = CNT_W'(GAP_CYC); nxt = ST_EN_B_GAP;
            end
            ST_EN_C: begin
                is_acc = 1'b1; req_wr = 1'b1; req_addr = ADDR_W'(ADR_KEY_FIRST);
                req_wdata = CMD_ENTER; tmr_val = CNT_W'(ENTRY_CYC); nxt = ST_SETTLE;
            end
            ST_RD_MFR: begin
                is_acc = 1'b1; req_addr = ADDR_W'(ADR_MAKER); nxt = ST_RD_DEV;
            end
            ST_RD_DEV: begin
                is_acc = 1'b1; req_addr = ADDR_W'(ADR_PART);
                if (mfr_id[BYTE_W-1:0] == CONT_CODE) nxt = ST_RD_MFR_X;
                else if (fin_data == CONT_CODE)      nxt = ST_RD_DEV_X;
                else                                 nxt = ST_EX_A;
            end
            ST_RD_MFR_X: begin
                is_acc = 1'b1; req_addr = ADDR_W'(ADR_MAKER_EXT);
                nxt = (dev_id[BYTE_W-1:0] == CONT_CODE) ? ST_RD_DEV_X : ST_EX_A;
            end
            ST_RD_DEV_X: begin
                is_acc = 1'b1; req_addr = ADDR_W'(ADR_PART_EXT); nxt = ST_EX_A;
            end
            ST_EX_A: begin
                is_acc = 1'b1; req_wr = 1'b1; req_addr = ADDR_W'(ADR_KEY_FIRST);
                req_wdata = KEY_FIRST; tmr_val = CNT_W'(GAP_CYC); nxt = ST_EX_A_GAP;
            end
            ST_EX_B: begin
                is_acc = 1'b1; req_wr = 1'b1; req_addr = ADDR_W'(ADR_KEY_SECOND);
                req_wdata = KEY_SECOND; tmr_val = CNT_W'(GAP_CYC); nxt = ST_EX_B_GAP;
            end
            ST_EX_C: begin
                is_acc = 1'b1; req_wr = 1'b1; req_addr = ADDR_W'(ADR_KEY_FIRST);
                req_wdata = CMD_LEAVE; tmr_val = CNT_W'(EXIT_CYC); nxt = ST_EX_WAIT;
            end
            ST_EN_A_GAP: begin is_wait = 1'b1; nxt = ST_EN_B;  end
            ST_EN_B_GAP: begin is_wait = 1'b1; nxt = ST_EN_C;  end
            ST_SETTLE:   begin is_wait = 1'b1; nxt = ST_RD_MFR; end
            ST_EX_A_GAP: begin is_wait = 1'b1; nxt = ST_EX_B;  end
            ST_EX_B_GAP: begin is_wait = 1'b1; nxt = ST_EX_C;  end
            ST_EX_WAIT:  begin is_wait = 1'b1; nxt = ST_FINISH; end
            ST_FINISH:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    assign req      = is_acc && !issued;
    assign tmr_load = is_acc && fin;
    assign busy     = (step != ST_IDLE);
    assign finish   = (step == ST_FINISH);

    // Advance the steps and capture the code bytes as reads complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= ST_IDLE;
            issued   <= 1'b0;
            mfr_id   <= '0;
            dev_id   <= '0;
            last_mfr <= '0;
        end else if (step == ST_IDLE) begin
            if (start) begin
                step   <= ST_EN_A;
                mfr_id <= '0;
                dev_id <= '0;
            end
        end else if (is_acc) begin
            if (req) issued <= 1'b1;
            if (fin) begin
                issued <= 1'b0;
                step   <= nxt;
                case (step)
                    ST_RD_MFR: begin
                        mfr_id   <= {{BYTE_W{1'b0}}, fin_data};
                        last_mfr <= fin_data;
                    end
                    ST_RD_DEV:   dev_id <= {{BYTE_W{1'b0}}, fin_data};
                    ST_RD_MFR_X: begin
                        mfr_id   <= {mfr_id[BYTE_W-1:0], fin_data};
                        last_mfr <= fin_data;
                    end
                    ST_RD_DEV_X: dev_id <= {dev_id[BYTE_W-1:0], fin_data};
                    default: ;
                endcase
            end
        end else if (is_wait) begin
            if (tmr_idle) step <= nxt;
        end else begin
            step <= nxt;
        end
    end

    // R9: finishing always returns the sequencer to idle on the next cycle
    a_r9_finish_once: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy);

    // R9: a start while running leaves the step unchanged unless fin or the timer moves it
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && is_acc && !fin) |=> (step == $past(step)));

endmodule

// File: rtl/flash_id_probe.sv
// Module: flash_id_probe (top)
// Probes a parallel flash for its extended manufacturer and device codes over
// a strobe/acknowledge byte bus, then registers the match and parity results.
// Assumes ADDR_W of at least 16 and delays given in clock cycles.
module flash_id_probe
    import flash_probe_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int GAP_CYC   = 1000,
    parameter int ENTRY_CYC = 1000000,
    parameter int EXIT_CYC  = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       exp_mfr,
    input  logic [15:0]       exp_dev,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic              bus_ack,
    output logic              busy,
    output logic              done,
    output logic              match,
    output logic              parity_err,
    output logic [15:0]       mfr_id,
    output logic [15:0]       dev_id
);

    localparam int MAX_A   = (GAP_CYC > EXIT_CYC) ? GAP_CYC : EXIT_CYC;
    localparam int MAX_CYC = (ENTRY_CYC > MAX_A) ? ENTRY_CYC : MAX_A;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) < 1 ? 1 : $clog2(MAX_CYC + 1);

    logic              req, req_wr, fin, tmr_load, tmr_idle, finish;
    logic [ADDR_W-1:0] req_addr;
    logic [BYTE_W-1:0] req_wdata, fin_data, last_mfr;
    logic [CNT_W-1:0]  tmr_val;
    logic [ID_W-1:0]   run_mfr, run_dev;
    logic              odd_ok, equal;

    probe_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .GAP_CYC(GAP_CYC),
        .ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .fin(fin), .fin_data(fin_data),
        .tmr_idle(tmr_idle), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .busy(busy), .finish(finish), .mfr_id(run_mfr), .dev_id(run_dev),
        .last_mfr(last_mfr)
    );

    probe_bus_port #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_port (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .fin(fin), .fin_data(fin_data)
    );

    probe_delay_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .idle(tmr_idle)
    );

    probe_id_eval u_eval (
        .mfr_id(run_mfr), .dev_id(run_dev), .last_mfr(last_mfr),
        .exp_mfr(exp_mfr), .exp_dev(exp_dev), .odd_ok(odd_ok), .equal(equal)
    );

    // Register the results when a probe finishes and hold them until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            match      <= 1'b0;
            parity_err <= 1'b0;
            mfr_id     <= '0;
            dev_id     <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                match      <= equal;
                parity_err <= !odd_ok;
                mfr_id     <= run_mfr;
                dev_id     <= run_dev;
            end
        end
    end

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: the entry command goes to the first key address
    a_r1_entry_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata == CMD_ENTER) |-> bus_addr == ADDR_W'(ADR_KEY_FIRST));

    // R5: the exit command goes to the first key address
    a_r5_exit_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata == CMD_LEAVE) |-> bus_addr == ADDR_W'(ADR_KEY_FIRST));

    // R7: a reported match agrees with the expected inputs at completion
    a_r7_match_means_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (done && match) |-> (mfr_id == $past(exp_mfr) && dev_id == $past(exp_dev)));

    // R10: no strobe while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_wr || bus_rd));

endmodule

// File: tb/flash_id_probe_test.sv
module flash_id_probe_test;

    localparam int GAP   = 3;
    localparam int ENTRY = 20;
    localparam int EXITW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] exp_mfr = '0, exp_dev = '0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata = '0;
    logic        bus_wr, bus_rd, bus_ack = 1'b0;
    logic        busy, done, match, parity_err;
    logic [15:0] mfr_id, dev_id;

    flash_id_probe #(.ADDR_W(16), .GAP_CYC(GAP), .ENTRY_CYC(ENTRY), .EXIT_CYC(EXITW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ack(bus_ack), .busy(busy),
        .done(done), .match(match), .parity_err(parity_err),
        .mfr_id(mfr_id), .dev_id(dev_id)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;

    task automatic check(input string tag, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0]  b0, b1, bx0, bx1;
        logic [15:0] em, ed;
        logic [3:0]  ws;
        logic        xm, xp;
        logic [15:0] xmid, xdid;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'hBF, 8'hB6, 8'hEE, 8'hEE, 16'h00BF, 16'h00B6, 4'd0, 1'b1, 1'b0, 16'h00BF, 16'h00B6},
        '{8'h7F, 8'h20, 8'h1F, 8'hEE, 16'h7F1F, 16'h0020, 4'd2, 1'b1, 1'b0, 16'h7F1F, 16'h0020},
        '{8'h03, 8'h7F, 8'hEE, 8'h45, 16'h0003, 16'h7F45, 4'd1, 1'b1, 1'b1, 16'h0003, 16'h7F45},
        '{8'h7F, 8'h7F, 8'h33, 8'h01, 16'h7F33, 16'h7F02, 4'd3, 1'b0, 1'b1, 16'h7F33, 16'h7F01},
        '{8'hC2, 8'h11, 8'hEE, 8'hEE, 16'h00C2, 16'h0012, 4'd0, 1'b0, 1'b0, 16'h00C2, 16'h0011},
        '{8'h7F, 8'h5A, 8'h1F, 8'hEE, 16'h001F, 16'h005A, 4'd1, 1'b0, 1'b0, 16'h7F1F, 16'h005A}
    };

    // memory model state and transaction log
    logic [7:0] mb0, mb1, mbx0, mbx1;
    int         ws = 0;
    int         wc = 0;
    int         rise_c = 0;
    logic [15:0] rise_addr;
    logic [7:0]  rise_data;
    int         hold_bad = 0;
    int         overlap_bad = 0;
    int         n_log = 0;
    logic        log_wr   [32];
    logic [15:0] log_addr [32];
    logic [7:0]  log_data [32];
    int          log_rise [32];
    int          log_end  [32];

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        case (a)
            16'h0000: return mb0;
            16'h0001: return mb1;
            16'h0100: return mbx0;
            16'h0101: return mbx1;
            default:  return 8'hFF;
        endcase
    endfunction

    // Byte-bus target with wait states, driven away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                bus_ack = 1'b0; wc = 0;
            end else if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_wr || bus_rd) begin
                if (bus_wr && bus_rd) overlap_bad++;
                if (wc == 0) begin
                    rise_c = cyc; rise_addr = bus_addr; rise_data = bus_wdata;
                end else if (bus_addr !== rise_addr || (bus_wr && bus_wdata !== rise_data)) begin
                    hold_bad++;
                end
                if (wc >= ws) begin
                    bus_ack   = 1'b1;
                    bus_rdata = bus_rd ? mem_rd(bus_addr) : 8'h00;
                    if (n_log < 32) begin
                        log_wr[n_log]   = bus_wr;
                        log_addr[n_log] = bus_addr;
                        log_data[n_log] = bus_wr ? bus_wdata : bus_rdata;
                        log_rise[n_log] = rise_c;
                        log_end[n_log]  = cyc;
                    end
                    n_log++;
                    wc = 0;
                end else begin
                    wc++;
                end
            end
        end
    end

    // watchdog
    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=%0h expected=%0h", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    int done_c = 0;

    task automatic run_probe(output logic ok);
        int t;
        ok = 1'b0;
        n_log = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1;                 // R9: ignored while busy
        @(negedge clk) start = 1'b0;
        for (t = 0; t < 3000; t++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        done_c = cyc;
    endtask

    initial begin
        logic got;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset strobes", !bus_wr && !bus_rd, {bus_wr, bus_rd}, 0);
        check("R10 reset flags", !busy && !done && !match && !parity_err,
              {busy, done, match, parity_err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 idle after reset", !busy && !bus_wr && !bus_rd && !done,
              {busy, bus_wr, bus_rd, done}, 0);

        for (int v = 0; v < NV; v++) begin
            vec_t  c;
            int    ne, bad, gap_bad;
            logic        ew [16];
            logic [15:0] ea [16];
            logic [7:0]  ed [16];
            c = VECS[v];
            mb0 = c.b0; mb1 = c.b1; mbx0 = c.bx0; mbx1 = c.bx1;
            exp_mfr = c.em; exp_dev = c.ed; ws = int'(c.ws);
            run_probe(got);
            check($sformatf("R9 done seen v%0d", v), got, got, 1);
            check($sformatf("R7 match v%0d", v), match === c.xm, match, c.xm);
            check($sformatf("R6 parity v%0d", v), parity_err === c.xp, parity_err, c.xp);
            check($sformatf("R4 mfr_id v%0d", v), mfr_id === c.xmid, mfr_id, c.xmid);
            check($sformatf("R3 dev_id v%0d", v), dev_id === c.xdid, dev_id, c.xdid);
            // expected transaction list
            ne = 0;
            ew[ne] = 1; ea[ne] = 16'h5555; ed[ne] = 8'hAA; ne++;
            ew[ne] = 1; ea[ne] = 16'h2AAA; ed[ne] = 8'h55; ne++;
            ew[ne] = 1; ea[ne] = 16'h5555; ed[ne] = 8'h90; ne++;
            ew[ne] = 0; ea[ne] = 16'h0000; ed[ne] = c.b0; ne++;
            ew[ne] = 0; ea[ne] = 16'h0001; ed[ne] = c.b1; ne++;
            if (c.b0 == 8'h7F) begin ew[ne] = 0; ea[ne] = 16'h0100; ed[ne] = c.bx0; ne++; end
            if (c.b1 == 8'h7F) begin ew[ne] = 0; ea[ne] = 16'h0101; ed[ne] = c.bx1; ne++; end
            ew[ne] = 1; ea[ne] = 16'h5555; ed[ne] = 8'hAA; ne++;
            ew[ne] = 1; ea[ne] = 16'h2AAA; ed[ne] = 8'h55; ne++;
            ew[ne] = 1; ea[ne] = 16'h5555; ed[ne] = 8'hF0; ne++;
            check($sformatf("R4 R9 access count v%0d", v), n_log == ne, n_log, ne);
            if (n_log == ne) begin
                bad = 0;
                for (int k = 0; k < 3; k++)
                    if (log_wr[k] !== ew[k] || log_addr[k] !== ea[k] || log_data[k] !== ed[k]) bad++;
                check($sformatf("R1 entry writes v%0d", v), bad == 0, bad, 0);
                bad = 0;
                for (int k = 3; k < ne - 3; k++)
                    if (log_wr[k] !== ew[k] || log_addr[k] !== ea[k] || log_data[k] !== ed[k]) bad++;
                check($sformatf("R3 R4 reads v%0d", v), bad == 0, bad, 0);
                bad = 0;
                for (int k = ne - 3; k < ne; k++)
                    if (log_wr[k] !== ew[k] || log_addr[k] !== ea[k] || log_data[k] !== ed[k]) bad++;
                check($sformatf("R5 exit writes v%0d", v), bad == 0, bad, 0);
                gap_bad = 0;
                if (log_rise[1] - log_end[0] <= GAP) gap_bad++;
                if (log_rise[2] - log_end[1] <= GAP) gap_bad++;
                if (log_rise[3] - log_end[2] <= ENTRY) gap_bad++;
                if (log_rise[ne-2] - log_end[ne-3] <= GAP) gap_bad++;
                if (log_rise[ne-1] - log_end[ne-2] <= GAP) gap_bad++;
                check($sformatf("R2 settle gaps v%0d", v), gap_bad == 0, gap_bad, 0);
                check($sformatf("R5 exit wait v%0d", v), done_c - log_end[ne-1] > EXITW,
                      done_c - log_end[ne-1], EXITW + 1);
            end
            @(negedge clk);
            check($sformatf("R9 done one cycle v%0d", v), !done, done, 0);
        end

        check("R8 hold until ack", hold_bad == 0, hold_bad, 0);
        check("R8 no strobe overlap", overlap_bad == 0, overlap_bad, 0);

        // R9: results hold after completion even when the expected inputs change
        begin
            logic m0, p0;
            int   n0;
            m0 = match; p0 = parity_err; n0 = n_log;
            exp_mfr = 16'h7F1F; exp_dev = 16'h005A;
            repeat (12) @(negedge clk);
            check("R9 flags hold", match === m0 && parity_err === p0, {match, parity_err}, {m0, p0});
            check("R9 no further access", n_log == n0 && !busy, n_log, n0);
        end

        // R10: reset in mid-probe returns to the quiet state
        mb0 = 8'hBF; mb1 = 8'hB6; exp_mfr = 16'h00BF; exp_dev = 16'h00B6; ws = 2;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 reset mid probe", !busy && !bus_wr && !bus_rd && !match && !done,
              {busy, bus_wr, bus_rd, match, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule